// File: doc/BRIEF.md
# Searchable Decode-to-Execute Buffer

This block is a shallow first-in first-out queue placed between the decode stage and the execute stage of a two-stage pipeline. Decode pushes instruction templates into it, and execute reads the oldest template and pops it when the template retires. Execute can also flush the whole queue in one cycle, for example after a taken branch.

The queue also has a combinational lookup. Decode presents a 5-bit register number, and the queue reports whether any template it holds will write that register. Decode uses this to stall when a source operand is still pending. Only templates that write a register can match: add-type and load-type. Branch-type and store-type templates never match. The template layout belongs to the user. The kind field and the destination field are placed by parameters, and so is the depth. Depths of one and two are the intended uses.

Top module: `pipe_sfifo`

## Requirements
- R1: After reset, empty is 1, full is 0 and find_hit is 0.
- R2: A push (enq_vld) while not full stores enq_data. Entries leave in arrival order, and first_data shows the oldest entry whenever empty is 0.
- R3: full is 1 when DEPTH entries are held. A push while full is dropped, even when a pop happens in the same cycle.
- R4: A pop (deq) while empty has no effect, and the queue stays empty.
- R5: clear empties the queue at the next edge and overrides any push or pop in the same cycle.
- R6: find_hit is 1 when a held entry has kind code 0 (add) or 2 (load) in bits [1:0] and its bits [6:2] equal find_key.
- R7: Entries with kind code 1 (branch) or 3 (store) never raise find_hit, whatever their bits [6:2] hold.
- R8: find_hit looks only at entries held in the current cycle. A template being pushed in that cycle is not searched, and a popped entry stops matching after the pop.
- R9: A push and a pop together, while neither full nor empty, both take effect and leave the occupancy unchanged.
- R10: With DEPTH set to 1, a single push makes the queue full, and a pop empties it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_vld | input | 1 | Push request |
| enq_data | input | DATA_W | Template to push |
| deq | input | 1 | Pop request |
| clear | input | 1 | Flush all entries |
| first_data | output | DATA_W | Oldest held template |
| full | output | 1 | No room for a push |
| empty | output | 1 | Nothing held |
| find_key | input | KEY_W | Register number to look up |
| find_hit | output | 1 | A held register-writing template targets find_key |

## Verification
On every cycle the assertions check several properties. A flush empties the queue. A refused push leaves a full queue and its head unchanged. An empty queue never reports a hit. A pop on an empty queue is ignored. The first push into an empty queue appears at the head. The bench scenarios are needed for the rest: the kind and destination decoding of the lookup, the blindness of the lookup to a push in the same cycle, ordering through the wrap of the pointers, the combined push and pop, and the one-entry variant.

// File: rtl/pipe_sfifo.sv
module pipe_sfifo #(
  parameter int DEPTH    = 2,
  parameter int DATA_W   = 32,
  parameter int KEY_W    = 5,
  parameter int KIND_W   = 2,
  parameter int KIND_LSB = 0,
  parameter int DST_LSB  = 2,
  parameter int WR_KIND_A = 0,
  parameter int WR_KIND_B = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_vld,
  input  logic [DATA_W-1:0] enq_data,
  input  logic              deq,
  input  logic              clear,
  output logic [DATA_W-1:0] first_data,
  output logic              full,
  output logic              empty,
  input  logic [KEY_W-1:0]  find_key,
  output logic              find_hit
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic [DEPTH-1:0]  hits;
  logic [PW-1:0]     rd_ptr, wr_ptr;
  logic [CW-1:0]     count;
  logic              do_enq, do_deq;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full       = (count == CW'(DEPTH));
  assign empty      = (count == '0);
  assign do_enq     = enq_vld & ~full & ~clear;
  assign do_deq     = deq & ~empty & ~clear;
  assign first_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      vld    <= '0;
    end else begin
      if (do_enq) begin
        vld[wr_ptr] <= 1'b1;
        wr_ptr      <= bump(wr_ptr);
      end
      if (do_deq) begin
        vld[rd_ptr] <= 1'b0;
        rd_ptr      <= bump(rd_ptr);
      end
      case ({do_enq, do_deq})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_enq) mem[wr_ptr] <= enq_data;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [KIND_W-1:0] kind;
    assign kind    = mem[i][KIND_LSB +: KIND_W];
    assign hits[i] = vld[i]
                   && (kind == KIND_W'(WR_KIND_A) || kind == KIND_W'(WR_KIND_B))
                   && (mem[i][DST_LSB +: KEY_W] == find_key);
  end

  assign find_hit = |hits;
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enq_vld,
  input logic              deq,
  input logic              clear,
  input logic [DATA_W-1:0] enq_data,
  input logic [DATA_W-1:0] first_data,
  input logic              full,
  input logic              empty,
  input logic              find_hit
);
  // R5
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> empty);

  // R3
  refused_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && enq_vld && !deq && !clear) |=> (full && $stable(first_data)));

  // R6
  empty_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !find_hit);

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && deq && !enq_vld && !clear) |=> empty);

  // R2
  first_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && enq_vld && !clear) |=> (!empty && first_data == $past(enq_data)));
endmodule

bind pipe_sfifo sfifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enq_vld(enq_vld), .deq(deq), .clear(clear),
  .enq_data(enq_data), .first_data(first_data), .full(full), .empty(empty),
  .find_hit(find_hit)
);

// File: tb/test_pipe_sfifo.sv
`timescale 1ns/1ps
module test_pipe_sfifo;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        enq_vld = 0, deq = 0, clear = 0;
  logic [31:0] enq_data = '0;
  logic [4:0]  find_key = '0;
  logic [31:0] first_data;
  logic        full, empty, find_hit;

  logic        e1 = 0, d1 = 0;
  logic [31:0] w1 = '0, f1;
  logic        full1, empty1, hit1;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  pipe_sfifo i_pipe_sfifo (
    .clk(clk), .rst_n(rst_n), .enq_vld(enq_vld), .enq_data(enq_data), .deq(deq),
    .clear(clear), .first_data(first_data), .full(full), .empty(empty),
    .find_key(find_key), .find_hit(find_hit));

  pipe_sfifo #(.DEPTH(1)) i_pipe_sfifo_d1 (
    .clk(clk), .rst_n(rst_n), .enq_vld(e1), .enq_data(w1), .deq(d1),
    .clear(1'b0), .first_data(f1), .full(full1), .empty(empty1),
    .find_key(5'd0), .find_hit(hit1));

  function automatic logic [31:0] tpl(input logic [1:0] kind, input logic [4:0] dst,
                                      input logic [24:0] tag);
    return {tag, dst, kind};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic [31:0] d, input logic q, input logic c);
    enq_vld = e; enq_data = d; deq = q; clear = c;
    @(posedge clk); #1;
    enq_vld = 0; deq = 0; clear = 0;
  endtask

  task automatic flush();
    step(0, '0, 0, 1);
  endtask

  task automatic t_reset();
    check("R1 empty", 32'(empty), 1);
    check("R1 full", 32'(full), 0);
    check("R1 find_hit", 32'(find_hit), 0);
  endtask

  task automatic t_order();
    logic [31:0] a, b;
    a = tpl(2'd0, 5'd3, 25'h11);
    b = tpl(2'd2, 5'd7, 25'h22);
    step(1, a, 0, 0);
    step(1, b, 0, 0);
    check("R3 full after two", 32'(full), 1);
    check("R2 head oldest", first_data, a);
    find_key = 5'd3; #1 check("R6 add hit", 32'(find_hit), 1);
    find_key = 5'd7; #1 check("R6 load hit", 32'(find_hit), 1);
    find_key = 5'd5; #1 check("R6 no match", 32'(find_hit), 0);
    step(1, tpl(2'd0, 5'd9, 25'h33), 0, 0);
    check("R3 push while full dropped head", first_data, a);
    step(0, '0, 1, 0);
    check("R2 second out", first_data, b);
    find_key = 5'd3; #1 check("R8 popped no match", 32'(find_hit), 0);
    step(0, '0, 1, 0);
    check("R2 empty after pops", 32'(empty), 1);
    find_key = 5'd9; #1 check("R3 dropped entry absent", 32'(find_hit), 0);
  endtask

  task automatic t_full_pushpop();
    logic [31:0] a, b;
    a = tpl(2'd0, 5'd1, 25'h41);
    b = tpl(2'd0, 5'd2, 25'h42);
    step(1, a, 0, 0);
    step(1, b, 0, 0);
    step(1, tpl(2'd0, 5'd12, 25'h43), 1, 0);
    check("R3 pop done when full", first_data, b);
    check("R3 push refused, not full", 32'(full), 0);
    find_key = 5'd12; #1 check("R3 refused not stored", 32'(find_hit), 0);
    step(0, '0, 1, 0);
    check("R3 only one remained", 32'(empty), 1);
  endtask

  task automatic t_empty_pop();
    logic [31:0] a;
    a = tpl(2'd2, 5'd6, 25'h51);
    step(0, '0, 1, 0);
    check("R4 still empty", 32'(empty), 1);
    step(1, a, 0, 0);
    check("R4 push then one entry", first_data, a);
    check("R4 not full", 32'(full), 0);
    flush();
  endtask

  task automatic t_kinds();
    step(1, tpl(2'd1, 5'd9, 25'h61), 0, 0);
    step(1, tpl(2'd3, 5'd9, 25'h62), 0, 0);
    find_key = 5'd9; #1 check("R7 branch/store never match", 32'(find_hit), 0);
    flush();
  endtask

  task automatic t_same_cycle();
    find_key = 5'd4;
    enq_vld = 1; enq_data = tpl(2'd0, 5'd4, 25'h71);
    #1 check("R8 pushing entry not searched", 32'(find_hit), 0);
    @(posedge clk); #1;
    enq_vld = 0;
    check("R8 searched once held", 32'(find_hit), 1);
    flush();
  endtask

  task automatic t_clear();
    step(1, tpl(2'd0, 5'd8, 25'h81), 0, 0);
    step(1, tpl(2'd0, 5'd8, 25'h82), 0, 0);
    step(1, tpl(2'd0, 5'd8, 25'h83), 1, 1);
    check("R5 clear wins empty", 32'(empty), 1);
    check("R5 clear not full", 32'(full), 0);
    find_key = 5'd8; #1 check("R5 no hit after clear", 32'(find_hit), 0);
  endtask

  task automatic t_simul();
    logic [31:0] a, b;
    a = tpl(2'd0, 5'd10, 25'h91);
    b = tpl(2'd2, 5'd11, 25'h92);
    step(1, a, 0, 0);
    step(1, b, 1, 0);
    check("R9 head replaced", first_data, b);
    check("R9 not empty", 32'(empty), 0);
    check("R9 not full", 32'(full), 0);
    find_key = 5'd10; #1 check("R9 old gone", 32'(find_hit), 0);
    find_key = 5'd11; #1 check("R9 new found", 32'(find_hit), 1);
    flush();
  endtask

  task automatic t_depth1();
    logic [31:0] a;
    a = tpl(2'd0, 5'd0, 25'hA1);
    e1 = 1; w1 = a;
    @(posedge clk); #1;
    check("R10 full after one", 32'(full1), 1);
    check("R10 head", f1, a);
    check("R10 hit", 32'(hit1), 1);
    w1 = tpl(2'd0, 5'd0, 25'hA2);
    @(posedge clk); #1;
    e1 = 0;
    check("R10 push while full dropped", f1, a);
    d1 = 1;
    @(posedge clk); #1;
    d1 = 0;
    check("R10 empty after pop", 32'(empty1), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_order();
    t_full_pushpop();
    t_empty_pop();
    t_kinds();
    t_same_cycle();
    t_clear();
    t_simul();
    t_depth1();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule